// File: doc/BRIEF.md
# Processed Image Readback Transmitter

This block sits after a per-pixel filter engine and before the serial link to the host. It counts the processed pixels that the engine reports, one pulse per pixel. When the count reaches the image size, it raises a flag to show that the result image is complete in the result RAM.

When the host side then asks for the result, the block reads the result RAM one byte at a time, starting at address zero and moving up in linear (row-major) order. Each byte goes out on a UART transmit line as one 8N1 frame. It fetches the next byte only after the current frame's stop bit has fully gone out. After the last frame it gives a one-cycle completion pulse, then clears its pixel count and the completion flag, ready for the next image.

The result RAM is external and has a one-cycle synchronous read: data for an address issued with the read strobe is expected on the data input in the following cycle.

Top module: `img_readback_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `tx_o` is high and `stored_o`, `rd_en_o` and `xfer_done_o` are low.
- R2: Each cycle with `pix_done_i` high while `stored_o` is low counts one pixel. `stored_o` goes high in the cycle after the IMG_ROWS*IMG_COLS-th counted pixel and stays high until the transfer completes.
- R3: `pix_done_i` pulses while `stored_o` is high are not counted. After a transfer, a new image again needs the full pixel count before `stored_o` rises.
- R4: `send_req_i` while `stored_o` is low is ignored: no RAM read is issued and `tx_o` stays high.
- R5: An accepted request reads addresses 0, 1, … IMG_ROWS*IMG_COLS-1 in increasing order, with one single-cycle `rd_en_o` strobe per byte. The next read is issued only after the previous frame's stop bit has ended.
- R6: Each byte is sent as one frame, with each bit held for CLKS_PER_BIT cycles: a low start bit, then 8 data bits LSB first, then a high stop bit. The byte sent is the RAM data returned in the cycle after its read strobe. The start bit of the first frame begins 3 cycles after the clock edge that samples the accepted request. Between frames the line stays high for exactly 3 cycles.
- R7: `xfer_done_o` is high for exactly one cycle, two cycles after the final stop bit ends. In the next cycle `stored_o` is low and the pixel count is zero.
- R8: `send_req_i` during a transfer has no effect on the byte stream or on its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_done_i | input | 1 | One-cycle pulse per processed pixel |
| send_req_i | input | 1 | Host-side request to return the result image |
| stored_o | output | 1 | Result image complete in RAM |
| rd_en_o | output | 1 | Result RAM read strobe |
| rd_addr_o | output | $clog2(IMG_ROWS*IMG_COLS) | Result RAM read address |
| rd_data_i | input | PIX_W | Result RAM read data, one cycle after strobe |
| tx_o | output | 1 | Serial transmit line, idles high |
| xfer_done_o | output | 1 | One-cycle pulse after the last frame |

## Verification
Some properties are checked on every cycle. The completion pulse lasts one cycle and clears the flag. Reads never happen without a stored image and are never back to back. Read addresses advance by one from zero within each transfer. The line is never driven low without a stored image.

Only the bench scenarios can show the rest, by comparing the serial line level against a reference model in every cycle. These cover the exact bit order and bit length, the three-cycle idle gaps, and the latency from request to start bit. They also cover that extra pixel pulses are not banked and that requests arriving too early or during a transfer leave no trace.

// File: rtl/img_rb_pkg.sv
package img_rb_pkg;
  typedef enum logic [2:0] {
    RB_IDLE,
    RB_FETCH,
    RB_LOAD,
    RB_SEND,
    RB_FIN
  } rb_state_e;
endpackage

// File: rtl/rb_pix_counter.sv
module rb_pix_counter #(
  parameter int NUM_PIX = 16384,
  localparam int CW = $clog2(NUM_PIX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pix_done_i,
  input  logic clear_i,
  output logic stored_o
);
  logic [CW-1:0] cnt_q;
  logic          stored_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stored_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q    <= '0;
      stored_q <= 1'b0;
    end else if (pix_done_i && !stored_q) begin
      cnt_q    <= cnt_q + 1'b1;
      stored_q <= (cnt_q == CW'(NUM_PIX - 1));
    end
  end

  assign stored_o = stored_q;
endmodule

// File: rtl/rb_uart_tx.sv
module rb_uart_tx #(
  parameter int DW           = 8,
  parameter int CLKS_PER_BIT = 87,
  localparam int FW     = DW + 2,
  localparam int BIT_CW = $clog2(FW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  output logic          done_o,
  output logic          tx_o
);
  logic [FW-1:0]     frame_q;
  logic              active_q;
  logic              done_q;
  logic [BIT_CW-1:0] bit_q;
  logic              tick;

  generate
    if (CLKS_PER_BIT <= 1) begin : g_nodiv
      assign tick = active_q;
    end else begin : g_div
      localparam int DCW = $clog2(CLKS_PER_BIT);
      logic [DCW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           div_q <= '0;
        else if (!active_q)    div_q <= '0;
        else if (tick)         div_q <= '0;
        else                   div_q <= div_q + 1'b1;
      end
      assign tick = active_q && (div_q == DCW'(CLKS_PER_BIT - 1));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q  <= '1;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      bit_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        frame_q  <= {1'b1, data_i, 1'b0};
        active_q <= 1'b1;
        bit_q    <= '0;
      end else if (tick) begin
        if (bit_q == BIT_CW'(FW - 1)) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          frame_q <= {1'b1, frame_q[FW-1:1]};
          bit_q   <= bit_q + 1'b1;
        end
      end
    end
  end

  assign tx_o   = active_q ? frame_q[0] : 1'b1;
  assign done_o = done_q;
endmodule

// File: rtl/rb_sequencer.sv
module rb_sequencer
  import img_rb_pkg::*;
#(
  parameter int NUM_PIX = 16384,
  parameter int DW      = 8,
  localparam int AW = $clog2(NUM_PIX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stored_i,
  input  logic          send_req_i,
  input  logic          tx_done_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          tx_start_o,
  output logic [DW-1:0] tx_data_o,
  output logic          xfer_done_o
);
  rb_state_e     state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          last_addr;

  assign last_addr = (addr_q == AW'(NUM_PIX - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RB_IDLE:  if (send_req_i && stored_i) state_d = RB_FETCH;
      RB_FETCH: state_d = RB_LOAD;
      RB_LOAD:  state_d = RB_SEND;
      RB_SEND:  if (tx_done_i) state_d = last_addr ? RB_FIN : RB_FETCH;
      RB_FIN:   state_d = RB_IDLE;
      default:  state_d = RB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RB_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == RB_IDLE)
        addr_q <= '0;
      else if (state_q == RB_SEND && tx_done_i && !last_addr)
        addr_q <= addr_q + 1'b1;
    end
  end

  assign rd_en_o     = (state_q == RB_FETCH);
  assign rd_addr_o   = addr_q;
  assign tx_start_o  = (state_q == RB_LOAD);
  assign tx_data_o   = rd_data_i;
  assign xfer_done_o = (state_q == RB_FIN);
endmodule

// File: rtl/img_readback_tx.sv
module img_readback_tx #(
  parameter int PIX_W        = 8,
  parameter int IMG_ROWS     = 128,
  parameter int IMG_COLS     = 128,
  parameter int CLKS_PER_BIT = 87,
  localparam int NUM_PIX = IMG_ROWS * IMG_COLS,
  localparam int AW      = $clog2(NUM_PIX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_done_i,
  input  logic             send_req_i,
  output logic             stored_o,
  output logic             rd_en_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [PIX_W-1:0] rd_data_i,
  output logic             tx_o,
  output logic             xfer_done_o
);
  logic             stored;
  logic             xfer_done;
  logic             tx_start;
  logic             tx_done;
  logic [PIX_W-1:0] tx_data;

  rb_pix_counter #(.NUM_PIX(NUM_PIX)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pix_done_i(pix_done_i),
    .clear_i   (xfer_done),
    .stored_o  (stored)
  );

  rb_sequencer #(.NUM_PIX(NUM_PIX), .DW(PIX_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stored_i   (stored),
    .send_req_i (send_req_i),
    .tx_done_i  (tx_done),
    .rd_en_o    (rd_en_o),
    .rd_addr_o  (rd_addr_o),
    .rd_data_i  (rd_data_i),
    .tx_start_o (tx_start),
    .tx_data_o  (tx_data),
    .xfer_done_o(xfer_done)
  );

  rb_uart_tx #(.DW(PIX_W), .CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tx_start),
    .data_i (tx_data),
    .done_o (tx_done),
    .tx_o   (tx_o)
  );

  assign stored_o    = stored;
  assign xfer_done_o = xfer_done;
endmodule

// File: rtl/img_readback_tx_chk.sv
module img_readback_tx_chk #(
  parameter int AW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stored_o,
  input logic          rd_en_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          tx_o,
  input logic          xfer_done_o
);
  logic [AW-1:0] exp_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          exp_addr_q <= '0;
    else if (xfer_done_o) exp_addr_q <= '0;
    else if (rd_en_o)     exp_addr_q <= exp_addr_q + 1'b1;
  end

  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |=> !xfer_done_o);
  p_done_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |=> !stored_o);
  p_stored_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stored_o && !xfer_done_o) |=> stored_o);
  p_no_read_unstored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> stored_o);
  p_read_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);
  p_addr_linear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (rd_addr_o == exp_addr_q));
  p_line_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_o |-> stored_o);
endmodule

bind img_readback_tx img_readback_tx_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stored_o   (stored_o),
  .rd_en_o    (rd_en_o),
  .rd_addr_o  (rd_addr_o),
  .tx_o       (tx_o),
  .xfer_done_o(xfer_done_o)
);

// File: tb/img_readback_tx_bench.sv
`timescale 1ns/1ps
module img_readback_tx_bench;
  localparam int ROWS = 2;
  localparam int COLS = 3;
  localparam int NPIX = ROWS * COLS;
  localparam int CPB  = 4;
  localparam int AW   = $clog2(NPIX);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_done = 1'b0;
  logic send_req = 1'b0;
  logic stored, rd_en, tx, xfer_done;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data = 8'h00;
  int seed = 0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  img_readback_tx #(.PIX_W(8), .IMG_ROWS(ROWS), .IMG_COLS(COLS), .CLKS_PER_BIT(CPB))
  u_img_readback_tx (
    .clk_i(clk), .rst_ni(rst_n), .pix_done_i(pix_done), .send_req_i(send_req),
    .stored_o(stored), .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .tx_o(tx), .xfer_done_o(xfer_done)
  );

  function automatic logic [7:0] ram_byte(int a, int s);
    return 8'((a * 37 + 91 + s * 53) & 255);
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= ram_byte(int'(rd_addr), seed);

  // reference model
  bit exp_tx_q[$];
  bit exp_dn_q[$];
  bit m_tx = 1, m_dn = 0, m_stored = 0, m_busy = 0;
  int m_cnt = 0;

  task automatic push_frame(logic [7:0] b);
    for (int k = 0; k < 10; k++) begin
      bit lvl;
      lvl = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : b[k-1];
      for (int c = 0; c < CPB; c++) begin exp_tx_q.push_back(lvl); exp_dn_q.push_back(0); end
    end
  endtask

  task automatic push_transfer();
    for (int i = 0; i < NPIX; i++) begin
      for (int g = 0; g < ((i == 0) ? 2 : 3); g++) begin exp_tx_q.push_back(1); exp_dn_q.push_back(0); end
      push_frame(ram_byte(i, seed));
    end
    exp_tx_q.push_back(1); exp_dn_q.push_back(0);
    exp_tx_q.push_back(1); exp_dn_q.push_back(1);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_tx_q.delete(); exp_dn_q.delete();
      m_tx = 1; m_dn = 0; m_stored = 0; m_busy = 0; m_cnt = 0;
    end else begin
      if (m_dn) begin
        m_cnt = 0; m_stored = 0; m_busy = 0;
      end else if (pix_done && !m_stored) begin
        m_cnt++;
        if (m_cnt == NPIX) m_stored = 1;
      end
      if (send_req && m_stored && !m_busy && !m_dn) begin
        m_busy = 1;
        push_transfer();
      end
      if (exp_tx_q.size() > 0) begin
        m_tx = exp_tx_q.pop_front();
        m_dn = exp_dn_q.pop_front();
      end else begin
        m_tx = 1; m_dn = 0;
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  int n_reads = 0;
  int exp_addr = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check(tx == m_tx, "R6 tx line", tx, m_tx);
      check(xfer_done == m_dn, "R7 xfer_done", xfer_done, m_dn);
      check(stored == m_stored, "R2 stored", stored, m_stored);
      if (xfer_done) exp_addr = 0;
      if (rd_en) begin
        n_reads++;
        check(int'(rd_addr) == exp_addr, "R5 read address", int'(rd_addr), exp_addr);
        exp_addr++;
      end
    end
  end

  task automatic pulses(int n, int gap);
    for (int i = 0; i < n; i++) begin
      pix_done = 1; @(negedge clk); pix_done = 0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic request();
    send_req = 1; @(negedge clk); send_req = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000; i++) begin
      if (xfer_done) break;
      @(negedge clk);
    end
    check(xfer_done == 1, "R7 transfer completes", xfer_done, 1);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tx == 1 && !stored && !rd_en && !xfer_done, "R1 reset state", {tx, stored, rd_en, xfer_done}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    check(tx == 1 && !stored && !rd_en && !xfer_done, "R1 after release", {tx, stored, rd_en, xfer_done}, 4'b1000);

    // R4: request before the image is stored
    request();
    repeat (20) @(negedge clk);
    check(n_reads == 0, "R4 early request ignored", n_reads, 0);

    // R2: count up to one short, then complete
    pulses(NPIX - 1, 1);
    check(stored == 0, "R2 not stored at N-1", stored, 0);
    pulses(1, 0);
    check(stored == 1, "R2 stored after N", stored, 1);

    // R3: extra pulses while stored
    pulses(3, 0);

    // R5/R6/R8: transfer with a stray request mid-way
    request();
    repeat (60) @(negedge clk);
    request();
    pulses(2, 0);
    wait_done();
    check(n_reads == NPIX, "R5 read count", n_reads, NPIX);
    check(stored == 0, "R7 stored cleared", stored, 0);

    // R3: earlier extra pulses not banked
    pulses(NPIX - 1, 0);
    repeat (4) @(negedge clk);
    check(stored == 0, "R3 count restarted", stored, 0);
    pulses(1, 0);
    check(stored == 1, "R3 stored after full count", stored, 1);

    // second image with different content, request held several cycles
    seed = 1;
    send_req = 1; repeat (5) @(negedge clk); send_req = 0;
    wait_done();
    check(n_reads == 2 * NPIX, "R5 second read count", n_reads, 2 * NPIX);
    repeat (10) @(negedge clk);
    check(tx == 1 && !stored, "R6 idle after transfer", {tx, stored}, 2'b10);
    summary();
  end
endmodule